// File: doc/BRIEF.md
# I2C Bus Phase Generator

This block is the bit-level timing engine of an I2C master. It takes one request at a time from a sequencer: a start condition, a repeated start, one data bit to write, one bit to read, or a stop condition. It then drives the SCL and SDA lines through the bus phases of that request. Every phase lasts a number of system clock cycles that comes from its own configuration input. Those inputs cover the SCL low and high times, the start hold, the repeated-start setup, the stop setup and hold, the delay before SDA may change after SCL falls, and the point after SCL rises at which SDA is sampled.

Both lines are open-drain. The block only asserts a pull-low enable for each line, so a released line reads high. It reports its current phase as a fixed 3-bit code. It pulses `done` for one cycle when a request has finished. It returns the SDA value it sampled during every data bit, whether that bit was written or read, so a sequencer can collect an acknowledge or a received bit. Between requests after a start, SCL stays held low until the next request. After a stop, both lines are released and the bus counts as free.

Top module: `i2c_phase_gen`

## Requirements
- R1: After reset, `phase` is 0, both pull-low enables are 0, `req_ready` is 1 and `done` is 0.
- R2: A start (kind 0) on a free bus pulls SDA low with SCL released in phase 1 for n(start hold) cycles. It then pulls SCL low, returns to phase 0 and pulses `done`. Here n(x) is x, or 1 when x is 0.
- R3: A write (kind 2) or read (kind 3) on a held bus runs through four phases in order:
  - phase 2 for n(SDA hold) cycles, with SCL low and SDA unchanged;
  - phase 3 for n(low) cycles, with SCL low and SDA set: pulled low for a written 0, released for a written 1 or a read;
  - phase 4 for n(sample) cycles, with SCL released;
  - phase 5 for n(high) cycles, with SCL released.

  The block then pulls SCL low and pulses `done`.
- R4: During the first cycle of phase 5, `rd_valid` is 1 and `rd_bit` holds the SDA line value at the end of phase 4. `rd_valid` is 0 in every other cycle. SDA does not change during phase 5.
- R5: A repeated start (kind 1) on a held bus runs phase 2 for n(SDA hold) cycles, then phase 3 with SDA released for n(low) cycles. It then runs phase 4 with SCL released for n(restart setup) cycles, then phase 1 with SDA low for n(start hold) cycles. It ends with SCL pulled low.
- R6: A stop (kind 4) on a held bus runs phase 2 for n(SDA hold) cycles, then phase 3 with SDA pulled low for n(low) cycles. It then runs phase 4 with SCL released for n(stop setup) cycles, then phase 6 with SDA released for n(stop hold) cycles. It ends with both lines released and the bus free.
- R7: A configured count of 0 makes its phase last exactly one cycle.
- R8: A request is taken only while `req_ready` is 1, which is the case only in phase 0. A request presented in any other phase has no effect.
- R9: `done` is a single-cycle pulse, given in phase 0 in the cycle after a request ends.
- R10: A write, read or stop on a free bus, or any kind code from 5 to 7, leaves both lines unchanged and stays in phase 0. Such a request pulses `done` in the cycle after it is accepted.
- R11: While SCL stays released, SDA changes only when entering phase 1 (start) or phase 6 (stop).
- R12: The phase codes are: 0 idle, 1 start, 2 low edge, 3 low, 4 high edge, 5 high, 6 stop. No other value appears.
- R13: A start on a held bus performs the repeated-start sequence, and a repeated start on a free bus performs the start sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | 0 start, 1 repeated start, 2 write bit, 3 read bit, 4 stop |
| req_bit | input | 1 | Data bit for a write |
| req_ready | output | 1 | High in phase 0; request taken when valid and ready |
| cfg_low | input | WIDE_W | SCL low cycles |
| cfg_high | input | WIDE_W | SCL high cycles |
| cfg_start_hold | input | NARROW_W | SDA fall to SCL fall cycles for a start |
| cfg_rs_setup | input | NARROW_W | SCL rise to SDA fall cycles for a repeated start |
| cfg_stop_setup | input | NARROW_W | SCL rise to SDA rise cycles for a stop |
| cfg_stop_hold | input | WIDE_W | Cycles held after the stop edge |
| cfg_sda_hold | input | NARROW_W | Cycles after the SCL fall before SDA changes |
| cfg_sample | input | NARROW_W | Cycles after the SCL rise before SDA is sampled |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| phase | output | 3 | Current phase code |
| done | output | 1 | One-cycle end-of-request pulse |
| rd_valid | output | 1 | Sampled bit valid |
| rd_bit | output | 1 | Sampled SDA value |

## Verification
The bench keeps the default 14-bit and 10-bit count widths and sets `SYNC_STAGES` to 0. With no synchronizer, the sampled bit follows the bench's line model in the same cycle, so the sample can be checked even when every count is zero. Phase counts are drawn from 0 to 6, so the zero-as-one rule is hit often and each request stays short enough for many random sequences. A slave pull-down model lets written ones be sampled as zeros, which is how an acknowledge looks on the bus.

// File: rtl/i2c_phase_pkg.sv
package i2c_phase_pkg;

   typedef enum logic [2:0] {
      PH_IDLE      = 3'd0,
      PH_START     = 3'd1,
      PH_LOW_EDGE  = 3'd2,
      PH_LOW       = 3'd3,
      PH_HIGH_EDGE = 3'd4,
      PH_HIGH      = 3'd5,
      PH_STOP      = 3'd6
   } phase_e;

   localparam logic [2:0] RQ_START   = 3'd0;
   localparam logic [2:0] RQ_RESTART = 3'd1;
   localparam logic [2:0] RQ_WRITE   = 3'd2;
   localparam logic [2:0] RQ_READ    = 3'd3;
   localparam logic [2:0] RQ_STOP    = 3'd4;

   typedef enum logic [3:0] {
      DS_NONE,
      DS_START_HOLD,
      DS_RS_SETUP,
      DS_SDA_HOLD,
      DS_LOW,
      DS_SAMPLE,
      DS_HIGH,
      DS_STOP_SETUP,
      DS_STOP_HOLD
   } dur_e;

   function automatic logic is_cond(input logic [2:0] k);
      return (k == RQ_START) || (k == RQ_RESTART);
   endfunction

   function automatic logic is_bit(input logic [2:0] k);
      return (k == RQ_WRITE) || (k == RQ_READ);
   endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] count,
   output logic         expired
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;

   // A loaded value of v gives max(v,1) cycles before expiry.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= (count == '0) ? '0 : count - ONE;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2c_sda_sync.sv
module i2c_sda_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '1;
      else begin
         sh_q[0] <= din;
         for (int i = 1; i < STAGES; i++)
            sh_q[i] <= sh_q[i-1];
      end
   end

   assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_phase_fsm.sv
module i2c_phase_fsm
   import i2c_phase_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [2:0] req_kind,
   input  logic       req_bit,
   input  logic       sda_s,
   input  logic       expired,
   output phase_e     phase,
   output logic       scl_low,
   output logic       sda_low,
   output logic       done,
   output logic       rd_valid,
   output logic       rd_bit,
   output dur_e       dsel,
   output logic       load
);
   phase_e     phase_q, ph_n;
   logic       scl_q, scl_n, sda_q, sda_n;
   logic [2:0] kind_q, kind_n;
   logic       bit_q, bit_n;
   logic       done_q, done_n, rdv_q, rdv_n, rdb_q, rdb_n;

   always_comb begin
      ph_n   = phase_q;
      scl_n  = scl_q;
      sda_n  = sda_q;
      kind_n = kind_q;
      bit_n  = bit_q;
      done_n = 1'b0;
      rdv_n  = 1'b0;
      rdb_n  = rdb_q;
      dsel   = DS_NONE;
      case (phase_q)
         PH_IDLE: if (req_valid) begin
            kind_n = req_kind;
            bit_n  = req_bit;
            if (is_cond(req_kind) && !scl_q) begin
               ph_n  = PH_START;
               sda_n = 1'b1;
               dsel  = DS_START_HOLD;
            end else if (scl_q && (is_cond(req_kind) || is_bit(req_kind) ||
                                   req_kind == RQ_STOP)) begin
               ph_n = PH_LOW_EDGE;
               dsel = DS_SDA_HOLD;
            end else begin
               done_n = 1'b1;
            end
         end
         PH_LOW_EDGE: if (expired) begin
            ph_n = PH_LOW;
            dsel = DS_LOW;
            if (kind_q == RQ_WRITE)     sda_n = !bit_q;
            else if (kind_q == RQ_STOP) sda_n = 1'b1;
            else                        sda_n = 1'b0;
         end
         PH_LOW: if (expired) begin
            ph_n  = PH_HIGH_EDGE;
            scl_n = 1'b0;
            if (is_bit(kind_q))         dsel = DS_SAMPLE;
            else if (kind_q == RQ_STOP) dsel = DS_STOP_SETUP;
            else                        dsel = DS_RS_SETUP;
         end
         PH_HIGH_EDGE: if (expired) begin
            if (is_bit(kind_q)) begin
               ph_n  = PH_HIGH;
               dsel  = DS_HIGH;
               rdv_n = 1'b1;
               rdb_n = sda_s;
            end else if (kind_q == RQ_STOP) begin
               ph_n  = PH_STOP;
               sda_n = 1'b0;
               dsel  = DS_STOP_HOLD;
            end else begin
               ph_n  = PH_START;
               sda_n = 1'b1;
               dsel  = DS_START_HOLD;
            end
         end
         PH_HIGH, PH_START: if (expired) begin
            ph_n   = PH_IDLE;
            scl_n  = 1'b1;
            done_n = 1'b1;
         end
         PH_STOP: if (expired) begin
            ph_n   = PH_IDLE;
            done_n = 1'b1;
         end
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         scl_q   <= 1'b0;
         sda_q   <= 1'b0;
         kind_q  <= RQ_START;
         bit_q   <= 1'b0;
         done_q  <= 1'b0;
         rdv_q   <= 1'b0;
         rdb_q   <= 1'b0;
      end else begin
         phase_q <= ph_n;
         scl_q   <= scl_n;
         sda_q   <= sda_n;
         kind_q  <= kind_n;
         bit_q   <= bit_n;
         done_q  <= done_n;
         rdv_q   <= rdv_n;
         rdb_q   <= rdb_n;
      end
   end

   assign load     = (dsel != DS_NONE);
   assign phase    = phase_q;
   assign scl_low  = scl_q;
   assign sda_low  = sda_q;
   assign done     = done_q;
   assign rd_valid = rdv_q;
   assign rd_bit   = rdb_q;
endmodule

// File: rtl/i2c_phase_gen.sv
module i2c_phase_gen
   import i2c_phase_pkg::*;
#(
   parameter int WIDE_W      = 14,
   parameter int NARROW_W    = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [2:0]          req_kind,
   input  logic                req_bit,
   output logic                req_ready,
   input  logic [WIDE_W-1:0]   cfg_low,
   input  logic [WIDE_W-1:0]   cfg_high,
   input  logic [NARROW_W-1:0] cfg_start_hold,
   input  logic [NARROW_W-1:0] cfg_rs_setup,
   input  logic [NARROW_W-1:0] cfg_stop_setup,
   input  logic [WIDE_W-1:0]   cfg_stop_hold,
   input  logic [NARROW_W-1:0] cfg_sda_hold,
   input  logic [NARROW_W-1:0] cfg_sample,
   input  logic                sda_in,
   output logic                scl_drive_low,
   output logic                sda_drive_low,
   output logic [2:0]          phase,
   output logic                done,
   output logic                rd_valid,
   output logic                rd_bit
);
   if (NARROW_W < 1 || NARROW_W > WIDE_W) begin : g_bad_width
      $error("i2c_phase_gen: NARROW_W must lie in 1..WIDE_W");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("i2c_phase_gen: SYNC_STAGES must not be negative");
   end

   logic              sda_s;
   logic              expired;
   logic              load;
   dur_e              dsel;
   phase_e            ph;
   logic [WIDE_W-1:0] dur;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign sda_s = sda_in;
   end else begin : g_sync
      i2c_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (sda_in),
         .dout (sda_s)
      );
   end

   always_comb begin
      case (dsel)
         DS_START_HOLD: dur = WIDE_W'(cfg_start_hold);
         DS_RS_SETUP:   dur = WIDE_W'(cfg_rs_setup);
         DS_SDA_HOLD:   dur = WIDE_W'(cfg_sda_hold);
         DS_LOW:        dur = cfg_low;
         DS_SAMPLE:     dur = WIDE_W'(cfg_sample);
         DS_HIGH:       dur = cfg_high;
         DS_STOP_SETUP: dur = WIDE_W'(cfg_stop_setup);
         DS_STOP_HOLD:  dur = cfg_stop_hold;
         default:       dur = '0;
      endcase
   end

   i2c_phase_timer #(.W(WIDE_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .count  (dur),
      .expired(expired)
   );

   i2c_phase_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_kind (req_kind),
      .req_bit  (req_bit),
      .sda_s    (sda_s),
      .expired  (expired),
      .phase    (ph),
      .scl_low  (scl_drive_low),
      .sda_low  (sda_drive_low),
      .done     (done),
      .rd_valid (rd_valid),
      .rd_bit   (rd_bit),
      .dsel     (dsel),
      .load     (load)
   );

   assign phase     = ph;
   assign req_ready = (ph == PH_IDLE);
endmodule

// File: rtl/i2c_phase_gen_chk.sv
module i2c_phase_gen_chk
   import i2c_phase_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] phase,
   input logic       scl_drive_low,
   input logic       sda_drive_low,
   input logic       done,
   input logic       rd_valid
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> phase == PH_IDLE); // R9
   AST_SCL_LOW_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW_EDGE || phase == PH_LOW) |-> scl_drive_low); // R3
   AST_SCL_FREE_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_START || phase == PH_HIGH_EDGE || phase == PH_HIGH ||
       phase == PH_STOP) |-> !scl_drive_low); // R3
   AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_HIGH |-> $stable(sda_drive_low)); // R4
   AST_RD_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> phase == PH_HIGH); // R4
   AST_SDA_EDGE_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_drive_low && !$past(scl_drive_low) && !$stable(sda_drive_low))
      |-> (phase == PH_START || phase == PH_STOP)); // R11
   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= 3'd6); // R12
endmodule

bind i2c_phase_gen i2c_phase_gen_chk u_chk (.*);

// File: tb/i2c_phase_gen_bench.sv
`timescale 1ns/1ps
module i2c_phase_gen_bench;
   localparam int W = 14;
   localparam int N = 10;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n;
   logic         req_valid;
   logic [2:0]   req_kind;
   logic         req_bit;
   logic         req_ready;
   logic [W-1:0] t_low, t_high, t_stop_hold;
   logic [N-1:0] t_start_hold, t_rs_setup, t_stop_setup, t_sda_hold, t_sample;
   logic         sda_in, scl_drive_low, sda_drive_low, done, rd_valid, rd_bit;
   logic [2:0]   phase;
   logic         slave_pull;

   assign sda_in = !sda_drive_low && !slave_pull;

   i2c_phase_gen #(.WIDE_W(W), .NARROW_W(N), .SYNC_STAGES(0)) u_i2c_phase_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_bit(req_bit), .req_ready(req_ready),
      .cfg_low(t_low), .cfg_high(t_high), .cfg_start_hold(t_start_hold),
      .cfg_rs_setup(t_rs_setup), .cfg_stop_setup(t_stop_setup),
      .cfg_stop_hold(t_stop_hold), .cfg_sda_hold(t_sda_hold),
      .cfg_sample(t_sample), .sda_in(sda_in),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .phase(phase), .done(done), .rd_valid(rd_valid), .rd_bit(rd_bit)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit m_scl = 0;
   bit m_sda = 0;

   int       nseg;
   bit [2:0] sp[4];
   int       sl[4];
   bit       ss[4];
   bit       sd[4];

   function automatic int nz(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic add_seg(input bit [2:0] p, input int len, input bit s, input bit d);
      sp[nseg] = p; sl[nseg] = len; ss[nseg] = s; sd[nseg] = d;
      nseg++;
   endtask

   task automatic run_req(input bit [2:0] kind, input bit b, input bit pull,
                          input bit poke);
      string tag;
      bit    e_scl, e_sda, exp_rd, first;
      int    exp_v, act_v;
      nseg = 0;
      e_scl = m_scl; e_sda = m_sda; exp_rd = 1'b0;
      if (kind <= 3'd1 && !m_scl) begin
         tag = (kind == 3'd1) ? "R13" : "R2";
         add_seg(3'd1, nz(int'(t_start_hold)), 0, 1);
         e_scl = 1; e_sda = 1;
      end else if (kind <= 3'd1) begin
         tag = (kind == 3'd0) ? "R13" : "R5";
         add_seg(3'd2, nz(int'(t_sda_hold)), 1, m_sda);
         add_seg(3'd3, nz(int'(t_low)), 1, 0);
         add_seg(3'd4, nz(int'(t_rs_setup)), 0, 0);
         add_seg(3'd1, nz(int'(t_start_hold)), 0, 1);
         e_scl = 1; e_sda = 1;
      end else if ((kind == 3'd2 || kind == 3'd3) && m_scl) begin
         bit d;
         tag = "R3";
         d = (kind == 3'd2) ? !b : 1'b0;
         add_seg(3'd2, nz(int'(t_sda_hold)), 1, m_sda);
         add_seg(3'd3, nz(int'(t_low)), 1, d);
         add_seg(3'd4, nz(int'(t_sample)), 0, d);
         add_seg(3'd5, nz(int'(t_high)), 0, d);
         e_scl = 1; e_sda = d;
         exp_rd = !d && !pull;
      end else if (kind == 3'd4 && m_scl) begin
         tag = "R6";
         add_seg(3'd2, nz(int'(t_sda_hold)), 1, m_sda);
         add_seg(3'd3, nz(int'(t_low)), 1, 1);
         add_seg(3'd4, nz(int'(t_stop_setup)), 0, 1);
         add_seg(3'd6, nz(int'(t_stop_hold)), 0, 0);
         e_scl = 0; e_sda = 0;
      end else begin
         tag = "R10";
      end

      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_bit = b; slave_pull = pull;
      @(negedge clk);
      req_valid = 1'b0;
      first = 1'b1;
      for (int s = 0; s < nseg; s++) begin
         for (int c = 0; c < sl[s]; c++) begin
            if (!first) begin
               @(negedge clk);
               req_valid = 1'b0;
            end
            first = 1'b0;
            exp_v = {sp[s], ss[s], sd[s], 1'b0, 1'b0, (sp[s] == 3'd5 && c == 0)};
            act_v = {phase, scl_drive_low, sda_drive_low, req_ready, done, rd_valid};
            check(act_v == exp_v, tag, "phase/scl/sda/ready/done/rdv", act_v, exp_v);
            if (sp[s] == 3'd5 && c == 0)
               check(rd_bit == exp_rd, "R4", "rd_bit", rd_bit, exp_rd);
            if (poke && s == 0 && c == 0) begin
               req_valid = 1'b1; // R8: must be ignored while busy
               req_kind = (kind == 3'd4) ? 3'd2 : 3'd4;
            end
         end
      end
      if (!first) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
      exp_v = {3'd0, e_scl, e_sda, 1'b1, 1'b1};
      act_v = {phase, scl_drive_low, sda_drive_low, req_ready, done};
      check(act_v == exp_v, poke ? "R8" : tag, "end phase/scl/sda/ready/done", act_v, exp_v);
      @(negedge clk);
      check(done == 1'b0, "R9", "done after pulse", done, 0);
      m_scl = e_scl; m_sda = e_sda;
   endtask

   task automatic set_all(input int v);
      t_low = W'(v); t_high = W'(v); t_stop_hold = W'(v);
      t_start_hold = N'(v); t_rs_setup = N'(v); t_stop_setup = N'(v);
      t_sda_hold = N'(v); t_sample = N'(v);
   endtask

   task automatic set_rand();
      t_low = W'($urandom_range(0, 6)); t_high = W'($urandom_range(0, 6));
      t_stop_hold = W'($urandom_range(0, 6));
      t_start_hold = N'($urandom_range(0, 6)); t_rs_setup = N'($urandom_range(0, 6));
      t_stop_setup = N'($urandom_range(0, 6)); t_sda_hold = N'($urandom_range(0, 6));
      t_sample = N'($urandom_range(0, 6));
   endtask

   bit finished = 0;

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_bit = 1'b0;
      slave_pull = 1'b0;
      set_all(0);
      repeat (3) @(negedge clk);
      check({phase, scl_drive_low, sda_drive_low, req_ready, done} == {3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
            "R1", "reset state", {phase, scl_drive_low, sda_drive_low, req_ready, done}, 6'b000_00_1 << 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(phase == 3'd0, "R12", "idle code", phase, 0);

      // R7: all counts zero, each phase one cycle
      run_req(3'd0, 0, 0, 0);
      run_req(3'd2, 1, 0, 0);
      run_req(3'd2, 0, 0, 0);
      run_req(3'd3, 0, 0, 0);
      run_req(3'd3, 0, 1, 0);
      run_req(3'd1, 0, 0, 0);
      run_req(3'd4, 0, 0, 0);
      // R10: bit, stop and unknown codes on a free bus
      run_req(3'd2, 0, 0, 0);
      run_req(3'd4, 0, 0, 0);
      run_req(3'd6, 1, 0, 0);
      // R13: repeated start on a free bus, start on a held bus
      set_all(3);
      run_req(3'd1, 0, 0, 1);
      run_req(3'd2, 1, 1, 1);  // R4: slave acknowledge pulls a written 1 low
      run_req(3'd0, 0, 0, 0);
      run_req(3'd7, 0, 0, 0);
      // long low/high times
      t_low = W'(25); t_high = W'(19); t_sample = N'(9); t_sda_hold = N'(7);
      run_req(3'd3, 0, 0, 0);
      run_req(3'd4, 0, 0, 1);

      for (int i = 0; i < 120; i++) begin
         bit [2:0] k;
         @(negedge clk);
         set_rand();
         if (!m_scl)
            k = ($urandom_range(0, 4) != 0) ? 3'($urandom_range(0, 1)) : 3'($urandom_range(2, 7));
         else
            k = 3'($urandom_range(0, 4));
         run_req(k, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 3) == 0);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule